// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core whose visible register set changes with the operating mode. Software addresses sixteen registers through a 4-bit index. Behind those sixteen names are thirty-one physical general-purpose words. A mode input picks which physical copy a given index reaches. Two combinational read ports and one clocked write port serve the instruction datapath. Every access is translated through the same index-to-slot mapping for the current mode.

Indices 0 to 7 are one set of words that every mode shares. The fast-interrupt mode has private copies of indices 8 to 12. The stack pointer (index 13) and the link register (index 14) have a private pair in each of the five exception modes, so each exception handler keeps its own stack and return address without saving anything. User and System modes share one pair. Index 15 is the program counter, a single word in every mode.

The block also holds the current status word and one saved-status word for each exception mode. Each has its own read and write port. A saved-status access goes to the word of the current mode. In a mode that has no saved-status word, the access reads zero and a write does nothing. Together with the banked link register, this lets an exception return restore the state it interrupted. In total the block holds 37 words of 32 bits.

Top module: `bkrf_top`

## Requirements
- R1: A synchronous active-high reset clears all 37 words. After reset, every read port returns zero for every mode and index.
- R2: Reads are combinational. A write with `wr_en` high takes effect at the rising clock edge. During the cycle of the write, a read of the same register returns the old value, and the new value appears after that edge.
- R3: Indices 0 to 7 are one physical set of words, shared by all modes. A write in any mode is seen at that index in every mode.
- R4: Indices 8 to 12 have a private copy in fast-interrupt mode (code 1). All other modes share one other copy.
- R5: Indices 13 and 14 have a separate physical pair for each exception mode: codes 1, 2, 3, 4 and 5. User and System modes share one further pair.
- R6: Index 15 is a single program-counter word that is the same in every mode.
- R7: Mode codes on `mode` are 0 User, 1 fast interrupt, 2 normal interrupt, 3 supervisor, 4 abort, 5 undefined and 6 System. System mode (code 6) and the unused code 7 reach exactly the registers that User mode reaches.
- R8: There is one current-status word. `cpsr_we` loads it from `cpsr_wdata` at the clock edge. `cpsr_rdata` shows it in every mode.
- R9: Each exception mode (codes 1 to 5) has its own saved-status word. This word is read on `spsr_rdata` and written through `spsr_we` and `spsr_wdata` while `mode` selects that mode.
- R10: In modes 0, 6 and 7, `spsr_rdata` reads zero and a saved-status write changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Current operating mode code |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| cpsr_we | input | 1 | Current-status write enable |
| cpsr_wdata | input | 32 | Current-status write data |
| cpsr_rdata | output | 32 | Current-status read data |
| spsr_we | input | 1 | Saved-status write enable for the current mode |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved-status read data for the current mode |

## Verification
A wrong slot mapping does not show up at the write itself. It shows up later, when the same index is read in another mode. Either a mode sees a value that was written somewhere else, or a value is missing where it should be shared. So the bench writes a distinct value into every index in every mode code. Then it reads all sixteen indices through both ports in all eight codes, and any aliasing is exposed in the cycle that follows the last write. Saved-status faults show up in the same way when every mode's word is read back after each mode has written. A stale read or a missing write shows up within one clock edge of the write.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;

    localparam int XLEN      = 32;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 3;
    localparam int N_XMODE   = 5;
    localparam int N_SHARED  = 8;
    localparam int HI_FIRST  = 8;
    localparam int HI_LAST   = 12;
    localparam int N_HIGH    = HI_LAST - HI_FIRST + 1;
    localparam int SP_IDX    = 13;
    localparam int PC_IDX    = 15;
    localparam int N_PAIRS   = N_XMODE + 1;
    localparam int PHYS_GPR  = N_SHARED + 2 * N_HIGH + 2 * N_PAIRS + 1;
    localparam int PHYS_W    = $clog2(PHYS_GPR);
    localparam int FIQ_BASE  = N_SHARED + N_HIGH;
    localparam int PAIR_BASE = FIQ_BASE + N_HIGH;
    localparam int PC_SLOT   = PHYS_GPR - 1;
    localparam int XSLOT_W   = $clog2(N_PAIRS);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 3'd0,
        MODE_FIQ = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_SVC = 3'd3,
        MODE_ABT = 3'd4,
        MODE_UND = 3'd5,
        MODE_SYS = 3'd6,
        MODE_RSV = 3'd7
    } cpu_mode_e;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [PHYS_W-1:0]  slot_t;
    typedef logic [XSLOT_W-1:0] xslot_t;

    typedef struct packed {
        logic  en;
        slot_t slot;
        word_t data;
    } gpr_wr_t;

    // Exception-mode bank number: 0 for the User/System group, 1..N_XMODE otherwise.
    function automatic xslot_t xslot_of(cpu_mode_e m);
        case (m)
            MODE_FIQ: return xslot_t'(1);
            MODE_IRQ: return xslot_t'(2);
            MODE_SVC: return xslot_t'(3);
            MODE_ABT: return xslot_t'(4);
            MODE_UND: return xslot_t'(5);
            default:  return xslot_t'(0);
        endcase
    endfunction

    function automatic slot_t phys_of(cpu_mode_e m, logic [IDX_W-1:0] idx);
        int i;
        int r;
        i = int'(idx);
        if (i == PC_IDX)
            r = PC_SLOT;
        else if (i < HI_FIRST)
            r = i;
        else if (i <= HI_LAST)
            r = (m == MODE_FIQ) ? FIQ_BASE + (i - HI_FIRST) : i;
        else
            r = PAIR_BASE + 2 * int'(xslot_of(m)) + (i - SP_IDX);
        return slot_t'(r);
    endfunction

endpackage

// File: rtl/bkrf_map.sv
module bkrf_map
    import bkrf_pkg::*;
(
    input  cpu_mode_e          mode,
    input  logic [IDX_W-1:0]   idx,
    output slot_t              slot
);
    always_comb slot = phys_of(mode, idx);
endmodule

// File: rtl/bkrf_gpr.sv
module bkrf_gpr
    import bkrf_pkg::*;
#(
    parameter int N_RD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  gpr_wr_t           wr,
    input  slot_t [N_RD-1:0]  rslot,
    output word_t [N_RD-1:0]  rdata
);
    word_t store [PHYS_GPR];

    for (genvar g = 0; g < PHYS_GPR; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (wr.en && wr.slot == slot_t'(g))
                store[g] <= wr.data;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb rdata[p] = store[rslot[p]];
    end
endmodule

// File: rtl/bkrf_status.sv
module bkrf_status
    import bkrf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cpu_mode_e mode,
    input  logic      cpsr_we,
    input  word_t     cpsr_wdata,
    output word_t     cpsr_rdata,
    input  logic      spsr_we,
    input  word_t     spsr_wdata,
    output word_t     spsr_rdata
);
    word_t                cpsr_q;
    word_t [N_XMODE-1:0]  spsr_q;
    xslot_t               xs;
    logic                 has_spsr;

    always_comb begin
        xs       = xslot_of(mode);
        has_spsr = (xs != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cpsr_q <= '0;
        else if (cpsr_we)
            cpsr_q <= cpsr_wdata;
    end

    for (genvar b = 0; b < N_XMODE; b++) begin : g_spsr
        always_ff @(posedge clk) begin
            if (rst)
                spsr_q[b] <= '0;
            else if (spsr_we && xs == xslot_t'(b + 1))
                spsr_q[b] <= spsr_wdata;
        end
    end

    always_comb begin
        cpsr_rdata = cpsr_q;
        spsr_rdata = '0;
        for (int b = 0; b < N_XMODE; b++)
            if (xs == xslot_t'(b + 1))
                spsr_rdata = spsr_q[b];
    end

    // R10: a saved-status write in a mode with no bank leaves all banks unchanged
    a_r10_spsr_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(spsr_we) && !$past(has_spsr)) |-> $stable(spsr_q));

    // R10: no saved-status word is visible in User, System or the unused code
    a_r10_spsr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !has_spsr |-> (spsr_rdata == '0));

    // R9: a saved-status write is seen in the next cycle if the mode has not changed
    a_r9_spsr_write_visible: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(spsr_we) && $past(has_spsr) && mode == $past(mode))
        |-> (spsr_rdata == $past(spsr_wdata)));

    // R8: the current-status word changes only when it is written
    a_r8_cpsr_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cpsr_we)) |-> $stable(cpsr_rdata));
endmodule

// File: rtl/bkrf_top.sv
module bkrf_top
    import bkrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode,
    input  logic [3:0]  ra_idx,
    output logic [31:0] ra_data,
    input  logic [3:0]  rb_idx,
    output logic [31:0] rb_data,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        cpsr_we,
    input  logic [31:0] cpsr_wdata,
    output logic [31:0] cpsr_rdata,
    input  logic        spsr_we,
    input  logic [31:0] spsr_wdata,
    output logic [31:0] spsr_rdata
);
    localparam int N_RD = 2;

    cpu_mode_e                 cur_mode;
    logic [N_RD-1:0][IDX_W-1:0] rd_idx;
    slot_t [N_RD-1:0]          rd_slot;
    word_t [N_RD-1:0]          rd_word;
    slot_t                     wr_slot;
    gpr_wr_t                   wr_req;

    always_comb begin
        cur_mode  = cpu_mode_e'(mode);
        rd_idx[0] = ra_idx;
        rd_idx[1] = rb_idx;
        wr_req    = '{en: wr_en, slot: wr_slot, data: wr_data};
        ra_data   = rd_word[0];
        rb_data   = rd_word[1];
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rmap
        bkrf_map u_map (.mode(cur_mode), .idx(rd_idx[p]), .slot(rd_slot[p]));
    end

    bkrf_map u_wmap (.mode(cur_mode), .idx(wr_idx), .slot(wr_slot));

    bkrf_gpr #(.N_RD(N_RD)) u_gpr (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_req),
        .rslot (rd_slot),
        .rdata (rd_word)
    );

    bkrf_status u_status (
        .clk        (clk),
        .rst        (rst),
        .mode       (cur_mode),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .cpsr_rdata (cpsr_rdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .spsr_rdata (spsr_rdata)
    );

    // R2: a written register reads back in the next cycle in the same mode
    a_r2_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ra_idx == $past(wr_idx) && mode == $past(mode))
        |-> (ra_data == $past(wr_data)));

    // R6: the program counter is one word whatever the mode
    a_r6_pc_shared: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_idx) == 4'd15 && rb_idx == 4'd15)
        |-> (rb_data == $past(wr_data)));

    // R3: low indices are shared across all modes
    a_r3_low_shared: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_idx) < 4'd8 && rb_idx == $past(wr_idx))
        |-> (rb_data == $past(wr_data)));

    // R8: a current-status write is seen in the next cycle in any mode
    a_r8_cpsr_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpsr_we)) |-> (cpsr_rdata == $past(cpsr_wdata)));
endmodule

// File: tb/tb_bkrf_top.sv
`timescale 1ns/1ps
module tb_bkrf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [31:0] ra_data, rb_data, wr_data = '0;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
    logic [31:0] cpsr_wdata = '0, cpsr_rdata, spsr_wdata = '0, spsr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] gm [0:63];
    logic [31:0] sm [0:7];
    logic [31:0] cm;

    always #2.5 clk = ~clk;

    bkrf_top dut (
        .clk(clk), .rst(rst), .mode(mode),
        .ra_idx(ra_idx), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata)
    );

    // exception bank number per R5/R9: codes 1..5 own a bank, others none
    function automatic int xb(int m);
        return (m >= 1 && m <= 5) ? m : 0;
    endfunction

    // model storage key for (mode, index), built from R3..R7
    function automatic int key(int m, int i);
        if (i < 8 || i == 15) return i;
        if (i <= 12) return (m == 1) ? 16 + i : i;
        return (xb(m) != 0) ? 32 + 2 * xb(m) + (i - 13) : i;
    endfunction

    function automatic string tag_of(int m, int i);
        if (m >= 6) return "R7";
        if (i < 8) return "R3";
        if (i <= 12) return "R4";
        if (i <= 14) return "R5";
        return "R6";
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 64; k++) gm[k] = '0;
        for (int k = 0; k < 8; k++) sm[k] = '0;
        cm = '0;
    endtask

    task automatic read_all(string force_tag);
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 16; i++) begin
                mode = 3'(m); ra_idx = 4'(i); rb_idx = 4'(15 - i);
                #0.1;
                chk(force_tag != "" ? force_tag : tag_of(m, i), "port A",
                    ra_data, gm[key(m, i)]);
                chk(force_tag != "" ? force_tag : tag_of(m, 15 - i), "port B",
                    rb_data, gm[key(m, 15 - i)]);
            end
            chk(force_tag != "" ? force_tag : "R8", "status", cpsr_rdata, cm);
            chk(force_tag != "" ? force_tag : (xb(m) != 0 ? "R9" : "R10"),
                "saved status", spsr_rdata, xb(m) != 0 ? sm[m] : 32'h0);
        end
    endtask

    task automatic gpr_write(int m, int i, logic [31:0] v);
        @(negedge clk);
        mode = 3'(m); wr_idx = 4'(i); wr_data = v; wr_en = 1'b1; ra_idx = 4'(i);
        #0.5;
        chk("R2", "old value before edge", ra_data, gm[key(m, i)]);
        @(posedge clk);
        gm[key(m, i)] = v;
        @(negedge clk);
        wr_en = 1'b0;
        #0.5;
        chk("R2", "new value after edge", ra_data, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_model();
        // R1: everything zero after reset
        do_reset();
        read_all("R1");

        // R3..R7: unique value into every index of every mode, forward order
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 16; i++)
                gpr_write(m, i, {8'hC3, 8'(m), 8'(i), 8'h01});
        read_all("");

        // reverse order, different pattern
        for (int m = 7; m >= 0; m--)
            for (int i = 15; i >= 0; i--)
                gpr_write(m, i, ~{8'(i), 8'(m), 8'h5A, 8'h02});
        read_all("");

        // R8: status word written from several modes
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mode = 3'(m); cpsr_we = 1'b1; cpsr_wdata = 32'h1000_0000 | (32'(m) << 4) | 32'h3;
            @(posedge clk);
            cm = cpsr_wdata;
            @(negedge clk);
            cpsr_we = 1'b0;
            for (int q = 0; q < 8; q++) begin
                mode = 3'(q);
                #0.1;
                chk("R8", "status across modes", cpsr_rdata, cm);
            end
        end

        // R9/R10: saved-status write attempted from every mode
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mode = 3'(m); spsr_we = 1'b1; spsr_wdata = 32'hA500_0000 | (32'(m) << 8) | 32'h77;
            #0.5;
            chk(xb(m) != 0 ? "R9" : "R10", "saved status before edge",
                spsr_rdata, xb(m) != 0 ? sm[m] : 32'h0);
            @(posedge clk);
            if (xb(m) != 0) sm[m] = spsr_wdata;
            @(negedge clk);
            spsr_we = 1'b0;
            read_all("");
        end

        // R1: reset again clears everything that was written
        do_reset();
        read_all("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule